// File: doc/BRIEF.md
# Stack and Interrupt-Entry Sequencer

This block carries out every stack operation of an 8-bit processor whose hardware stack sits in a single 256-byte page. It handles several kinds of operation:

- pushing and pulling one accumulator or index register;
- pushing and pulling the status register;
- saving and restoring a subroutine return address;
- software-break entry through a fixed two-byte vector;
- return from interrupt.

The stack pointer and the status register live inside the block. The instruction decoder starts an operation with a one-cycle request and hands over the current register values. The block then walks the memory accesses the operation needs, one per clock cycle, on a byte-wide memory port. That port has a combinational read.

When the last access is done, the updated stack pointer, status, program counter and any pulled byte are visible, and a one-cycle done pulse is raised. The stack pointer is 8 bits wide and post-decrements on a push and pre-increments on a pull, so it wraps within the stack page. Return addresses follow a minus-one convention on call and a plus-one convention on return.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer is 0xFF, status is 0x24, pc_o is 0x0000, done_o is low and no memory access is requested.
- R2: Op codes 0, 1 and 2 push a_i, x_i and y_i. The byte is written to {0x01, S}, and S then becomes S-1 modulo 256, so 0x00 wraps to 0xFF.
- R3: Op codes 4, 5 and 6 pull into data_o. S first becomes S+1 modulo 256, and the byte is then read from {0x01, S}. Status bit 7 becomes bit 7 of the byte and bit 1 becomes 1 exactly when the byte is zero. All other status bits are kept.
- R4: Op code 3 writes the status byte with bit 5 forced to 1 at {0x01, S} and decrements S.
- R5: Op code 7 pulls a byte into status with bit 5 forced to 1 and bit 4 forced to 0.
- R6: Op code 8 (call) writes (pc_i-1)[15:8] at {0x01, S} and (pc_i-1)[7:0] at {0x01, S-1}. S drops by 2 and pc_o becomes target_i.
- R7: Op code 9 (return) pulls a low byte and then a high byte, and sets pc_o to that word plus 1.
- R8: Op code 10 (break) pushes (pc_i+1) high byte, then low byte, then status with bits 5 and 4 set. It sets status bit 2 and clears bit 3. It then reads the low byte at 0xFFFE and the high byte at 0xFFFF and loads pc_o with that word.
- R9: Op code 11 (return from interrupt) pulls status with the forcing of R5, then the low byte and the high byte of the address, and sets pc_o to that word plus 1.
- R10: Op code 12 copies x_i into S with no memory access, and status is left unchanged.
- R11: An operation makes one access per cycle in the order above. done_o is high for exactly one cycle, in the cycle after the final step. An operation with no access takes one step.
- R12: A start_i request made while an operation is in progress is ignored. Op codes 13 to 15 make no access and change no register, but still pulse done_o.
- R13: A memory write and a memory read are never requested in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation, sampled while idle |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y index value |
| pc_i | input | 16 | Current program counter |
| target_i | input | 16 | Call destination address |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe |
| sp_o | output | 8 | Stack pointer |
| status_o | output | 8 | Status register |
| pc_o | output | 16 | Updated program counter |
| data_o | output | 8 | Last byte pulled into A, X or Y |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that memory read data is valid combinationally in the cycle of the read strobe. They also assume that only the stack page and the two vector bytes are ever addressed, which holds because the block forms every address itself. The operand inputs are taken to be stable only at the cycle where start_i is sampled, since the block latches them there.

The stimulus uses a memory model that answers reads at once. It drives operands and start_i only at falling edges. Each operation runs to its done pulse before the next request, except in the one test that holds start_i high through a break sequence on purpose.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int DW = 8;
  localparam int AW = 16;
  localparam int MAX_STEPS = 5;
  localparam int STEP_W = $clog2(MAX_STEPS);

  // status bit positions
  localparam int BIT_NEG  = 7;
  localparam int BIT_ONE  = 5;
  localparam int BIT_BRK  = 4;
  localparam int BIT_DEC  = 3;
  localparam int BIT_IRQ  = 2;
  localparam int BIT_ZERO = 1;

  typedef enum logic [3:0] {
    OP_PUSH_A = 4'd0, OP_PUSH_X = 4'd1, OP_PUSH_Y = 4'd2, OP_PUSH_P = 4'd3,
    OP_PULL_A = 4'd4, OP_PULL_X = 4'd5, OP_PULL_Y = 4'd6, OP_PULL_P = 4'd7,
    OP_CALL   = 4'd8, OP_RET    = 4'd9, OP_BRK    = 4'd10, OP_RTI   = 4'd11,
    OP_XFER_S = 4'd12
  } op_e;

  typedef enum logic [1:0] {ACC_NONE, ACC_PUSH, ACC_PULL, ACC_VEC} acc_e;
  typedef enum logic [2:0] {DST_NONE, DST_REG, DST_STAT, DST_LO, DST_HI, DST_VHI} dst_e;

  typedef struct packed {
    acc_e          acc;
    dst_e          dst;
    logic [DW-1:0] wdata;
    logic          vec_idx;
    logic          set_irq;
    logic          last;
  } step_t;
endpackage

// File: rtl/stack_seq_step.sv
module stack_seq_step
  import stack_seq_pkg::*;
(
  input  op_e               op_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     x_i,
  input  logic [DW-1:0]     y_i,
  input  logic [AW-1:0]     pc_i,
  input  logic [DW-1:0]     status_i,
  output step_t             step_o
);
  localparam logic [DW-1:0] ONE_MASK = DW'(1) << BIT_ONE;
  localparam logic [DW-1:0] BRK_MASK = DW'(1) << BIT_BRK;

  logic [AW-1:0] ret_m1, brk_p1;
  assign ret_m1 = pc_i - AW'(1);
  assign brk_p1 = pc_i + AW'(1);

  always_comb begin
    step_o         = '0;
    step_o.acc     = ACC_NONE;
    step_o.dst     = DST_NONE;
    step_o.last    = 1'b1;
    case (op_i)
      OP_PUSH_A: begin step_o.acc = ACC_PUSH; step_o.wdata = a_i; end
      OP_PUSH_X: begin step_o.acc = ACC_PUSH; step_o.wdata = x_i; end
      OP_PUSH_Y: begin step_o.acc = ACC_PUSH; step_o.wdata = y_i; end
      OP_PUSH_P: begin step_o.acc = ACC_PUSH; step_o.wdata = status_i | ONE_MASK; end
      OP_PULL_A, OP_PULL_X, OP_PULL_Y: begin
        step_o.acc = ACC_PULL; step_o.dst = DST_REG;
      end
      OP_PULL_P: begin step_o.acc = ACC_PULL; step_o.dst = DST_STAT; end
      OP_CALL: begin
        step_o.acc = ACC_PUSH;
        if (step_i == '0) begin
          step_o.wdata = ret_m1[AW-1:DW];
          step_o.last  = 1'b0;
        end else begin
          step_o.wdata = ret_m1[DW-1:0];
        end
      end
      OP_RET: begin
        step_o.acc = ACC_PULL;
        if (step_i == '0) begin
          step_o.dst  = DST_LO;
          step_o.last = 1'b0;
        end else begin
          step_o.dst  = DST_HI;
        end
      end
      OP_BRK: begin
        step_o.last = 1'b0;
        case (step_i)
          STEP_W'(0): begin step_o.acc = ACC_PUSH; step_o.wdata = brk_p1[AW-1:DW]; end
          STEP_W'(1): begin step_o.acc = ACC_PUSH; step_o.wdata = brk_p1[DW-1:0]; end
          STEP_W'(2): begin
            step_o.acc     = ACC_PUSH;
            step_o.wdata   = status_i | ONE_MASK | BRK_MASK;
            step_o.set_irq = 1'b1;
          end
          STEP_W'(3): begin step_o.acc = ACC_VEC; step_o.dst = DST_LO; end
          default: begin
            step_o.acc     = ACC_VEC;
            step_o.dst     = DST_VHI;
            step_o.vec_idx = 1'b1;
            step_o.last    = 1'b1;
          end
        endcase
      end
      OP_RTI: begin
        step_o.acc  = ACC_PULL;
        step_o.last = 1'b0;
        case (step_i)
          STEP_W'(0): step_o.dst = DST_STAT;
          STEP_W'(1): step_o.dst = DST_LO;
          default: begin step_o.dst = DST_HI; step_o.last = 1'b1; end
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_seq_flags.sv
module stack_seq_flags
  import stack_seq_pkg::*;
(
  input  logic [DW-1:0] status_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] stat_pull_o,
  output logic [DW-1:0] stat_nz_o,
  output logic [DW-1:0] stat_brk_o
);
  for (genvar i = 0; i < DW; i++) begin : g_pull
    if (i == BIT_ONE) begin : g_one
      assign stat_pull_o[i] = 1'b1;
    end else if (i == BIT_BRK) begin : g_zero
      assign stat_pull_o[i] = 1'b0;
    end else begin : g_copy
      assign stat_pull_o[i] = rdata_i[i];
    end
  end

  always_comb begin
    stat_nz_o           = status_i;
    stat_nz_o[BIT_NEG]  = rdata_i[DW-1];
    stat_nz_o[BIT_ZERO] = (rdata_i == '0);
    stat_brk_o          = status_i;
    stat_brk_o[BIT_IRQ] = 1'b1;
    stat_brk_o[BIT_DEC] = 1'b0;
  end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
  parameter logic [7:0]  SP_RESET   = 8'hFF,
  parameter logic [7:0]  STAT_RESET = 8'h24
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [3:0]  op_i,
  input  logic [7:0]  a_i,
  input  logic [7:0]  x_i,
  input  logic [7:0]  y_i,
  input  logic [15:0] pc_i,
  input  logic [15:0] target_i,
  input  logic [7:0]  mem_rdata_i,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  output logic        mem_we_o,
  output logic        mem_re_o,
  output logic [7:0]  sp_o,
  output logic [7:0]  status_o,
  output logic [15:0] pc_o,
  output logic [7:0]  data_o,
  output logic        done_o
);
  logic              busy_q, done_q;
  logic [STEP_W-1:0] step_q;
  op_e               op_q;
  logic [DW-1:0]     a_q, x_q, y_q, sp_q, stat_q, tmp_q, data_q;
  logic [AW-1:0]     pc_in_q, tgt_q, pc_q;
  step_t             st;
  logic [DW-1:0]     stat_pull, stat_nz, stat_brk;
  logic [AW-1:0]     word;

  stack_seq_step u_step (
    .op_i(op_q), .step_i(step_q), .a_i(a_q), .x_i(x_q), .y_i(y_q),
    .pc_i(pc_in_q), .status_i(stat_q), .step_o(st)
  );

  stack_seq_flags u_flags (
    .status_i(stat_q), .rdata_i(mem_rdata_i),
    .stat_pull_o(stat_pull), .stat_nz_o(stat_nz), .stat_brk_o(stat_brk)
  );

  always_comb begin
    mem_addr_o = '0;
    case (st.acc)
      ACC_PUSH: mem_addr_o = {STACK_PAGE, sp_q};
      ACC_PULL: mem_addr_o = {STACK_PAGE, sp_q + DW'(1)};
      ACC_VEC:  mem_addr_o = {VEC_ADDR[AW-1:1], st.vec_idx};
      default:  mem_addr_o = '0;
    endcase
    if (!busy_q) mem_addr_o = '0;
  end

  assign mem_we_o    = busy_q && (st.acc == ACC_PUSH);
  assign mem_re_o    = busy_q && (st.acc == ACC_PULL || st.acc == ACC_VEC);
  assign mem_wdata_o = mem_we_o ? st.wdata : '0;
  assign word        = {mem_rdata_i, tmp_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= '0;
      op_q    <= OP_PUSH_A;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      pc_in_q <= '0;
      tgt_q   <= '0;
      sp_q    <= SP_RESET;
      stat_q  <= STAT_RESET;
      pc_q    <= '0;
      tmp_q   <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          step_q  <= '0;
          op_q    <= op_e'(op_i);
          a_q     <= a_i;
          x_q     <= x_i;
          y_q     <= y_i;
          pc_in_q <= pc_i;
          tgt_q   <= target_i;
        end
      end else begin
        case (st.acc)
          ACC_PUSH: sp_q <= sp_q - DW'(1);
          ACC_PULL: sp_q <= sp_q + DW'(1);
          default: ;
        endcase
        case (st.dst)
          DST_REG:  begin data_q <= mem_rdata_i; stat_q <= stat_nz; end
          DST_STAT: stat_q <= stat_pull;
          DST_LO:   tmp_q  <= mem_rdata_i;
          DST_HI:   pc_q   <= word + AW'(1);
          DST_VHI:  pc_q   <= word;
          default: ;
        endcase
        if (st.set_irq) stat_q <= stat_brk;
        if (st.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          if (op_q == OP_CALL)   pc_q <= tgt_q;
          if (op_q == OP_XFER_S) sp_q <= x_q;
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  assign sp_o     = sp_q;
  assign status_o = stat_q;
  assign pc_o     = pc_q;
  assign data_o   = data_q;
  assign done_o   = done_q;
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_ADDR   = 16'hFFFE
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] mem_addr_o,
  input logic        mem_we_o,
  input logic        mem_re_o,
  input logic [7:0]  sp_o,
  input logic [7:0]  status_o,
  input logic        done_o
);
  logic stack_rd;
  assign stack_rd = mem_re_o && (mem_addr_o[15:8] == STACK_PAGE);

  assert_push_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o == {STACK_PAGE, sp_o});

  assert_push_dec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> sp_o == 8'($past(sp_o) - 8'd1));

  assert_pull_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_rd |-> mem_addr_o[7:0] == 8'(sp_o + 8'd1));

  assert_pull_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_rd |=> sp_o == 8'($past(sp_o) + 8'd1));

  assert_vec_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_re_o && !stack_rd) |-> mem_addr_o[15:1] == VEC_ADDR[15:1]);

  assert_fixed_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[5] && !status_o[4]);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_we_o && !mem_re_o);

  assert_rw_excl_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && mem_re_o));
endmodule

bind stack_seq stack_seq_chk #(.STACK_PAGE(STACK_PAGE), .VEC_ADDR(VEC_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o),
  .mem_re_o(mem_re_o), .sp_o(sp_o), .status_o(status_o), .done_o(done_o)
);

// File: tb/stack_seq_test.sv
`timescale 1ns/1ps
module stack_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [7:0]  a_i = '0, x_i = '0, y_i = '0;
  logic [15:0] pc_i = '0, target_i = '0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic [7:0]  wdata, sp, status, data;
  logic        we, re, done;
  logic [15:0] pc;

  logic [7:0] stk [0:255];
  logic [7:0] vec_lo = 8'h00, vec_hi = 8'hF0;
  int wr_cnt = 0, rd_cnt = 0, clash_cnt = 0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // {push op, pull op, value}
  localparam logic [15:0] TBL [8] = '{
    16'h0400, 16'h1580, 16'h267F, 16'h0501,
    16'h16FF, 16'h2400, 16'h04C3, 16'h165A
  };

  always #2.5 clk = ~clk;

  stack_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .x_i(x_i), .y_i(y_i), .pc_i(pc_i), .target_i(target_i),
    .mem_rdata_i(rdata), .mem_addr_o(addr), .mem_wdata_o(wdata),
    .mem_we_o(we), .mem_re_o(re), .sp_o(sp), .status_o(status),
    .pc_o(pc), .data_o(data), .done_o(done)
  );

  always_comb begin
    if (addr[15:8] == 8'h01)   rdata = stk[addr[7:0]];
    else if (addr == 16'hFFFE) rdata = vec_lo;
    else if (addr == 16'hFFFF) rdata = vec_hi;
    else                       rdata = 8'hEE;
  end

  always @(posedge clk) begin
    if (we && addr[15:8] == 8'h01) stk[addr[7:0]] <= wdata;
    if (we) wr_cnt <= wr_cnt + 1;
    if (re) rd_cnt <= rd_cnt + 1;
    if (we && re) clash_cnt <= clash_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] x,
                        input logic [7:0] y, input logic [15:0] p, input logic [15:0] t,
                        output int lat);
    @(negedge clk);
    op_i = op; a_i = a; x_i = x; y_i = y; pc_i = p; target_i = t;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic preload(input logic [7:0] val);
    logic [7:0] idx;
    idx = sp + 8'd1;
    stk[idx] = val;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL R11 watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat, w0, r0;
    logic [7:0] s0, st0, v;
    logic [3:0] pu, pl;
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sp", 32'(sp), 32'h00FF);
    chk("R1 status", 32'(status), 32'h0024);
    chk("R1 pc", 32'(pc), 32'h0000);
    chk("R1 done", 32'(done), 32'h0);
    chk("R1 access", 32'({we, re}), 32'h0);

    // table walk: push then pull
    for (int i = 0; i < 8; i++) begin
      pu = TBL[i][15:12]; pl = TBL[i][11:8]; v = TBL[i][7:0];
      s0 = sp;
      run_op(pu, v, v, v, 16'h0, 16'h0, lat);
      chk("R2 stored byte", 32'(stk[s0]), 32'(v));
      chk("R2 sp after push", 32'(sp), 32'(8'(s0 - 8'd1)));
      chk("R11 push latency", 32'(lat), 32'd2);
      st0 = status;
      run_op(pl, 8'h11, 8'h22, 8'h33, 16'h0, 16'h0, lat);
      chk("R3 pulled data", 32'(data), 32'(v));
      chk("R3 sp after pull", 32'(sp), 32'(s0));
      chk("R3 N flag", 32'(status[7]), 32'(v[7]));
      chk("R3 Z flag", 32'(status[1]), 32'(v == 8'h00));
      chk("R3 other flags", 32'(status & 8'h7D), 32'(st0 & 8'h7D));
      chk("R11 pull latency", 32'(lat), 32'd2);
    end

    // status pull and push
    preload(8'hDB);
    run_op(4'd7, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R5 pulled status", 32'(status), 32'h00EB);
    s0 = sp;
    run_op(4'd3, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R4 pushed status", 32'(stk[s0]), 32'h00EB);
    chk("R4 sp", 32'(sp), 32'(8'(s0 - 8'd1)));

    // call / return with low-byte borrow
    s0 = sp;
    run_op(4'd8, 8'h0, 8'h0, 8'h0, 16'h1200, 16'hABCD, lat);
    chk("R6 high byte", 32'(stk[s0]), 32'h0011);
    chk("R6 low byte", 32'(stk[8'(s0 - 8'd1)]), 32'h00FF);
    chk("R6 sp", 32'(sp), 32'(8'(s0 - 8'd2)));
    chk("R6 pc", 32'(pc), 32'hABCD);
    chk("R11 call latency", 32'(lat), 32'd3);
    run_op(4'd9, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R7 pc", 32'(pc), 32'h1200);
    chk("R7 sp", 32'(sp), 32'(s0));
    chk("R11 return latency", 32'(lat), 32'd3);

    // break entry
    preload(8'h09);
    run_op(4'd7, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R5 status set", 32'(status), 32'h0029);
    s0 = sp; w0 = wr_cnt; r0 = rd_cnt;
    run_op(4'd10, 8'h0, 8'h0, 8'h0, 16'h2000, 16'h0, lat);
    chk("R8 pc high", 32'(stk[s0]), 32'h0020);
    chk("R8 pc low", 32'(stk[8'(s0 - 8'd1)]), 32'h0001);
    chk("R8 status byte", 32'(stk[8'(s0 - 8'd2)]), 32'h0039);
    chk("R8 status reg", 32'(status), 32'h0025);
    chk("R8 vector pc", 32'(pc), 32'hF000);
    chk("R8 sp", 32'(sp), 32'(8'(s0 - 8'd3)));
    chk("R8 access count", 32'((wr_cnt - w0) * 16 + (rd_cnt - r0)), 32'h32);
    chk("R11 break latency", 32'(lat), 32'd6);

    // return from interrupt
    run_op(4'd11, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R9 status", 32'(status), 32'h0029);
    chk("R9 pc", 32'(pc), 32'h2002);
    chk("R9 sp", 32'(sp), 32'(s0));
    chk("R11 rti latency", 32'(lat), 32'd4);

    // X to S, then wrap
    st0 = status; w0 = wr_cnt; r0 = rd_cnt;
    run_op(4'd12, 8'h0, 8'h00, 8'h0, 16'h0, 16'h0, lat);
    chk("R10 sp", 32'(sp), 32'h0000);
    chk("R10 status", 32'(status), 32'(st0));
    chk("R10 no access", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
    chk("R11 xfer latency", 32'(lat), 32'd2);
    run_op(4'd0, 8'hA5, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R2 wrap store", 32'(stk[0]), 32'h00A5);
    chk("R2 wrap sp", 32'(sp), 32'h00FF);
    run_op(4'd4, 8'h0, 8'h0, 8'h0, 16'h0, 16'h0, lat);
    chk("R3 wrap data", 32'(data), 32'h00A5);
    chk("R3 wrap sp", 32'(sp), 32'h0000);

    // start held high through a break
    s0 = sp; w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk);
    op_i = 4'd10; pc_i = 16'h3000; start_i = 1'b1;
    @(negedge clk);
    op_i = 4'd0; a_i = 8'h77;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    start_i = 1'b0;
    @(negedge clk);
    chk("R12 busy writes", 32'(wr_cnt - w0), 32'd3);
    chk("R12 busy reads", 32'(rd_cnt - r0), 32'd2);
    chk("R12 busy sp", 32'(sp), 32'(8'(s0 - 8'd3)));

    // unused op code
    s0 = sp; st0 = status; w0 = wr_cnt; r0 = rd_cnt;
    run_op(4'd14, 8'h1, 8'h2, 8'h3, 16'h4444, 16'h5555, lat);
    chk("R12 nop latency", 32'(lat), 32'd2);
    chk("R12 nop access", 32'((wr_cnt - w0) + (rd_cnt - r0)), 32'd0);
    chk("R12 nop regs", {sp, status, pc}, {s0, st0, 16'hF000});
    chk("R13 no clash", 32'(clash_cnt), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule